// File: doc/BRIEF.md
# Watchdog Countdown Timer

This block is an 8-bit down-counter for a system controller that has to raise an event a whole number of time units after software arms it. Software writes a start value, picks one of several slow rates, and puts the timer into watchdog mode. From then on, each enable pulse of the chosen rate takes one off the count. When the count reaches zero, counting stops and an expiry flag is set. The flag can also drive an interrupt line.

The timer runs on the system clock. It never sees a slow clock directly. Instead, a set of single-cycle enable pulses arrives on `tick_in`, one wire for each source rate. Software reaches the timer through a byte-wide register port with a combinational read path.

The expiry flag is read-only and clears itself when software reads the register that holds it. The interrupt line works in one of two styles: it can follow the flag as a level, or it can emit a short pulse of fixed length each time the timer expires.

Top module: `wdt_top`

## Requirements
- R1: After reset, every register reads 0x00, `irq` is low and the live count is zero.
- R2: A write to address 0x11 loads the counter and also stores that byte as the reload value. A read of 0x11 returns the live remaining count. If a load and a tick fall in the same cycle, the load wins.
- R3: Only when bits 2:1 of address 0x0F hold 10 (watchdog mode) does each selected tick reduce the count by one. The codes 00, 01 and 11 hold the count unchanged.
- R4: Bits 2:0 of address 0x10 choose which `tick_in` wire drives the counter. Pulses on the other wires are ignored, and a code at or above NRATE never ticks.
- R5: When the count steps from one to zero, bit 7 of address 0x01 (the expiry flag) becomes 1. The count then stays at zero under further ticks.
- R6: A read of address 0x01 returns the flag and then clears it. A write cannot change the flag. Bit 2 of 0x01 is the interrupt enable, which can be both read and written.
- R7: If an expiry lands in the same cycle as a read of 0x01, the flag is left set afterwards.
- R8: A write that moves the mode field into 10 from any other code reloads the counter with the stored reload value.
- R9: When bit 7 of 0x0F is 0 (level style), `irq` equals the expiry flag ANDed with the interrupt enable.
- R10: When bit 7 of 0x0F is 1 (pulse style) and the interrupt enable is set, `irq` is high for exactly PULSE_LEN clocks after an expiry. The length of the pulse does not depend on when the flag is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | NRATE | One-cycle enable pulses, one wire per source rate |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes read side effects) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Timer interrupt |

## Verification
The bench builds the block with NRATE = 6 and PULSE_LEN = 4. With only six rates, source codes 6 and 7 have no wire behind them, so the bench can show that those codes starve the counter even when every tick wire pulses. With a four-clock pulse, the bench can count the whole interrupt pulse, plus the quiet cycles on either side, in a short window. Counts of one and five keep each expiry within a few ticks. This makes it cheap to line up the same-cycle collisions: a load against a tick, and an expiry against a flag read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int ADDR_W = 5;
   localparam logic [ADDR_W-1:0] A_STAT = 5'h01;
   localparam logic [ADDR_W-1:0] A_TCTL = 5'h0F;
   localparam logic [ADDR_W-1:0] A_TSRC = 5'h10;
   localparam logic [ADDR_W-1:0] A_TCNT = 5'h11;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_PLAIN = 2'b01,
      MODE_WDOG  = 2'b10,
      MODE_RSVD  = 2'b11
   } tmode_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
   parameter int SRC_W = 3,
   parameter int NRATE = 8
) (
   input  logic [NRATE-1:0] tick_in,
   input  logic [SRC_W-1:0] src,
   output logic             tick
);
   localparam int NSRC = 2 ** SRC_W;
   logic [NSRC-1:0] rate_vec;

   for (genvar g = 0; g < NSRC; g++) begin : g_rate
      if (g < NRATE) begin : g_wired
         assign rate_vec[g] = tick_in[g];
      end else begin : g_empty
         assign rate_vec[g] = 1'b0;
      end
   end

   assign tick = rate_vec[src];
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             reload,
   input  logic             active,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q, rld_q;
   logic             step;

   assign step   = active && tick && (cnt_q != '0) && !load && !reload;
   assign expire = step && (cnt_q == CNT_W'(1));
   assign count  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         rld_q <= load_val;
      end else if (reload) begin
         cnt_q <= rld_q;
      end else if (step) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/wdt_irq_shaper.sv
module wdt_irq_shaper #(
   parameter int PULSE_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulsed,
   input  logic ien,
   input  logic flag,
   input  logic expire,
   output logic irq
);
   logic pulse_on;

   if (PULSE_LEN == 1) begin : g_one
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= 1'b0;
         else        p_q <= expire && ien;
      end
      assign pulse_on = p_q;
   end else begin : g_cnt
      localparam int PW = $clog2(PULSE_LEN + 1);
      logic [PW-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               p_q <= '0;
         else if (expire && ien)   p_q <= PW'(PULSE_LEN);
         else if (p_q != '0)       p_q <= p_q - PW'(1);
      end
      assign pulse_on = (p_q != '0);
   end

   assign irq = pulsed ? pulse_on : (flag && ien);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
   import wdt_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int SRC_W     = 3,
   parameter int NRATE     = 8,
   parameter int PULSE_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NRATE-1:0]  tick_in,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq
);
   if (NRATE < 1 || NRATE > 2 ** SRC_W) begin : g_bad_nrate
      $error("wdt_top: NRATE must lie in 1..2**SRC_W");
   end
   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("wdt_top: PULSE_LEN must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 8 || SRC_W < 1 || SRC_W > 8) begin : g_bad_width
      $error("wdt_top: CNT_W must be 2..8 and SRC_W 1..8");
   end

   tmode_e           mode_q;
   logic             pulsed_q, ien_q, flag_q;
   logic [SRC_W-1:0] src_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wr_stat, wr_tctl, wr_tsrc, wr_tcnt, rd_stat;
   logic             enter_wd, active, tick, expire;
   tmode_e           mode_new;
   logic             unused_wdata;

   assign wr_stat  = reg_wr && (reg_addr == A_STAT);
   assign wr_tctl  = reg_wr && (reg_addr == A_TCTL);
   assign wr_tsrc  = reg_wr && (reg_addr == A_TSRC);
   assign wr_tcnt  = reg_wr && (reg_addr == A_TCNT);
   assign rd_stat  = reg_rd && (reg_addr == A_STAT);
   assign mode_new = tmode_e'(reg_wdata[2:1]);
   assign enter_wd = wr_tctl && (mode_new == MODE_WDOG) && (mode_q != MODE_WDOG);
   assign active   = (mode_q == MODE_WDOG);
   assign unused_wdata = ^{reg_wdata[6:3], reg_wdata[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_OFF;
         pulsed_q <= 1'b0;
         ien_q    <= 1'b0;
         src_q    <= '0;
      end else begin
         if (wr_tctl) begin
            mode_q   <= mode_new;
            pulsed_q <= reg_wdata[7];
         end
         if (wr_stat) ien_q <= reg_wdata[2];
         if (wr_tsrc) src_q <= reg_wdata[SRC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (expire)  flag_q <= 1'b1;
      else if (rd_stat) flag_q <= 1'b0;
   end

   wdt_tick_sel #(.SRC_W(SRC_W), .NRATE(NRATE)) u_sel (
      .tick_in(tick_in), .src(src_q), .tick(tick)
   );

   wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(wr_tcnt), .load_val(reg_wdata[CNT_W-1:0]),
      .reload(enter_wd), .active(active), .tick(tick), .count(cnt_q), .expire(expire)
   );

   wdt_irq_shaper #(.PULSE_LEN(PULSE_LEN)) u_irq (
      .clk(clk), .rst_n(rst_n), .pulsed(pulsed_q), .ien(ien_q), .flag(flag_q),
      .expire(expire), .irq(irq)
   );

   always_comb begin
      reg_rdata = 8'h00;
      case (reg_addr)
         A_STAT:  reg_rdata = {flag_q, 4'b0000, ien_q, 2'b00};
         A_TCTL:  reg_rdata = {pulsed_q, 4'b0000, mode_q, 1'b0};
         A_TSRC:  reg_rdata = 8'(src_q);
         A_TCNT:  reg_rdata = 8'(cnt_q);
         default: reg_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             active,
   input logic             tick,
   input logic             load,
   input logic             reload,
   input logic             expire,
   input logic             flag,
   input logic             rd_stat,
   input logic             pulsed,
   input logic             ien,
   input logic             irq
);
   p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load && !reload) |=> $stable(count));

   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tick && count != '0 && !load && !reload) |=> (count == $past(count) - CNT_W'(1)));

   p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load && !reload) |=> (count == '0));

   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> flag);

   p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !expire) |=> !flag);

   p_pulse_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pulsed && ien && expire) |=> irq);
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .count(cnt_q), .active(active), .tick(tick),
   .load(wr_tcnt), .reload(enter_wd), .expire(expire), .flag(flag_q),
   .rd_stat(rd_stat), .pulsed(pulsed_q), .ien(ien_q), .irq(irq)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
   localparam int NR = 6;
   localparam int PL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] tick_in = '0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [4:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          irq;
   int            n_chk = 0, n_bad = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   wdt_top #(.NRATE(NR), .PULSE_LEN(PL)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1 reg_rd = 1'b0;
   endtask

   task automatic tk(input logic [NR-1:0] pat);
      @(negedge clk);
      tick_in = pat;
      @(posedge clk); #1 tick_in = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(5'h01, d); chk("R1 stat", d, 8'h00);
      rd(5'h0F, d); chk("R1 tctl", d, 8'h00);
      rd(5'h11, d); chk("R1 count", d, 8'h00);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_load_hold();
      logic [7:0] d;
      wr(5'h11, 8'd5); rd(5'h11, d); chk("R2 load readback", d, 5);
      tk('1); rd(5'h11, d); chk("R3 mode 00 holds", d, 5);
      wr(5'h0F, 8'h02); tk('1); rd(5'h11, d); chk("R3 mode 01 holds", d, 5);
   endtask

   task automatic t_countdown();
      logic [7:0] d;
      wr(5'h10, 8'd2);
      wr(5'h0F, 8'h04); rd(5'h11, d); chk("R8 enter reload", d, 5);
      tk(NR'(1) << 1); rd(5'h11, d); chk("R4 other rate ignored", d, 5);
      tk(NR'(1) << 2); rd(5'h11, d); chk("R3 step", d, 4);
      for (int i = 0; i < 4; i++) tk(NR'(1) << 2);
      rd(5'h11, d); chk("R5 at zero", d, 0);
      rd(5'h01, d); chk("R5 flag set", d, 8'h80);
      rd(5'h01, d); chk("R6 cleared by read", d, 8'h00);
      tk(NR'(1) << 2); rd(5'h11, d); chk("R5 stays zero", d, 0);
      rd(5'h01, d); chk("R5 no new expiry", d, 8'h00);
   endtask

   task automatic t_stat_write();
      logic [7:0] d;
      wr(5'h01, 8'h80); rd(5'h01, d); chk("R6 flag not writable", d, 8'h00);
      wr(5'h01, 8'h84); rd(5'h01, d); chk("R6 enable rw", d, 8'h04);
   endtask

   task automatic t_level_irq();
      logic [7:0] d;
      wr(5'h11, 8'd1); tk(NR'(1) << 2);
      chk("R9 level irq high", irq, 1);
      rd(5'h01, d); chk("R9 flag seen", d, 8'h84);
      chk("R9 level irq drops", irq, 0);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(5'h11, 8'd1);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 5'h01; tick_in = NR'(1) << 2;
      #1 d = reg_rdata; chk("R7 pre-expiry read", d, 8'h04);
      @(posedge clk); #1 reg_rd = 1'b0; tick_in = '0;
      rd(5'h01, d); chk("R7 flag kept", d, 8'h84);
      wr(5'h11, 8'd3);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 5'h11; reg_wdata = 8'd9; tick_in = NR'(1) << 2;
      @(posedge clk); #1 reg_wr = 1'b0; tick_in = '0;
      rd(5'h11, d); chk("R2 load beats tick", d, 9);
   endtask

   task automatic t_pulse_irq();
      logic [7:0] d;
      int highs = 0;
      wr(5'h0F, 8'h84); wr(5'h11, 8'd1);
      chk("R10 quiet before", irq, 0);
      tk(NR'(1) << 2);
      for (int i = 0; i < PL + 2; i++) begin
         @(negedge clk); #1 if (irq) highs++;
      end
      chk("R10 pulse length", highs, PL);
      rd(5'h01, d); chk("R10 flag independent", d, 8'h84);
   endtask

   task automatic t_dead_codes();
      logic [7:0] d;
      wr(5'h10, 8'd7); wr(5'h11, 8'd3);
      tk('1); rd(5'h11, d); chk("R4 code 7 no tick", d, 3);
      wr(5'h10, 8'd6); tk('1); rd(5'h11, d); chk("R4 code 6 no tick", d, 3);
      wr(5'h10, 8'd5); tk('1); rd(5'h11, d); chk("R4 code 5 ticks", d, 2);
      wr(5'h0F, 8'h00); rd(5'h11, d); chk("R8 leave keeps count", d, 2);
      wr(5'h0F, 8'h04); rd(5'h11, d); chk("R8 re-enter reloads", d, 3);
      wr(5'h0F, 8'h04); tk('1); rd(5'h11, d); chk("R8 stay no reload", d, 2);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_load_hold();
      t_countdown();
      t_stat_write();
      t_level_irq();
      t_collide();
      t_pulse_irq();
      t_dead_codes();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got 0x0 expected 0x1 (run finished)");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule